// File: doc/BRIEF.md
# Serial EEPROM Command Front-End

This block is the slave-side command engine of a 4096-byte serial EEPROM. The bus host selects the device by pulling the active-low select low. It then shifts in an 8-bit opcode, a 16-bit address and, for writes, data bytes. All fields travel most significant bit first. The block decodes six opcodes. It keeps the write-enable latch and fetches read data from a synchronous array port. It shifts read data and status back out on the serial output, and passes write bytes with their page-wrapped addresses to a separate write controller. That controller reports its internal write cycle on `wr_busy`.

All serial pins are sampled in the system clock domain. They must already be synchronous to `clk`. SCK edges are found by comparing each sample with the previous one, so SCK high and low times must each last at least three `clk` cycles. Clock idle-low (mode 0,0) and idle-high (mode 1,1) both work, because data is taken only on SCK rising edges and driven only on falling edges. A hold input freezes the transfer without losing its place.

Top module: `spiee_front`

## Requirements
- R1: While selected and not held, SI is captured on each SCK rising edge, most significant bit first. The first capture is the first rising edge after `cs_n` falls, in both SCK idle-low and idle-high use.
- R2: Opcodes are: 03h read, 02h write, 06h set write enable, 04h clear write enable, 05h status read, 01h status write. Status write is accepted, but its payload changes nothing. Any other opcode makes the block ignore the rest of the transfer until `cs_n` rises: `so_oe` stays low and no write bytes are emitted.
- R3: A read takes a 16-bit address after the opcode, and its top 4 bits are ignored. The addressed byte then appears on `so`, most significant bit first, with `so_oe` high. `so` changes only after SCK falling edges.
- R4: After each read byte, the read address increments by one. Address 0FFFh is followed by 0000h.
- R5: The write-enable latch changes only when `cs_n` rises directly after the 8 bits of the 06h or 04h opcode: 06h sets it and 04h clears it. If one more SCK rising edge arrives first, the latch keeps its value.
- R6: The status read returns bit 0 = `wr_busy`, bit 1 = write-enable latch and bits 7:2 = `stat_hi`. The byte is repeated for as long as the host keeps clocking.
- R7: While `hold_n` is low, SCK edges are ignored and `so_oe` is low. When `hold_n` goes high, the transfer resumes at the same bit, with the same `so` value.
- R8: When `wr_busy` is high at the end of the opcode, a read is refused: `so_oe` stays low for the whole transfer. A write is refused in the same case. A status read still works.
- R9: A write is accepted only when the latch is set and `wr_busy` is low. Each complete data byte of an accepted write is emitted once on `wbyte_valid`/`wbyte_addr`/`wbyte_data`. The address advances only in its low 5 bits, so it wraps within its 32-byte page. A refused write emits nothing.
- R10: When `cs_n` rises during write data, `wr_commit` pulses if the rise is on a byte boundary and at least one byte was sent. Otherwise `wr_abort` pulses.
- R11: A falling edge of `wr_busy` clears the write-enable latch.
- R12: `so_oe` is low out of reset and whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low select |
| hold_n | input | 1 | Active-low transfer pause |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so (low = high impedance) |
| stat_hi | input | 6 | Upper status bits supplied from outside |
| wr_busy | input | 1 | Internal write cycle in progress |
| mem_rd_en | output | 1 | Array read strobe |
| mem_rd_addr | output | ADDR_W | Array read address |
| mem_rdata | input | 8 | Array read data, valid one clk after the strobe |
| wbyte_valid | output | 1 | One write byte is available |
| wbyte_addr | output | ADDR_W | Page-wrapped address of that byte |
| wbyte_data | output | 8 | Write byte value |
| wr_commit | output | 1 | Pulse: start the write cycle for the staged bytes |
| wr_abort | output | 1 | Pulse: discard the staged bytes |

## Verification
The bench uses the default ADDR_W = 12 and PAGE_W = 5. With these values, the wrap from 0FFFh to 0000h and the wrap inside a 32-byte page each take only a few bytes to reach. The bench write controller holds `wr_busy` for 600 clocks. That is long enough for a status read and a refused read to both start inside the write cycle. Transfers run in both SCK idle levels, and one hold pause is placed mid-byte during read data.

// File: rtl/spiee_pkg.sv
package spiee_pkg;
  typedef enum logic [2:0] {
    PH_CMD, PH_ADH, PH_ADL, PH_RD, PH_WR, PH_STAT, PH_WELP, PH_IGN
  } phase_e;

  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
endpackage

// File: rtl/spiee_rst_sync.sv
module spiee_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign srst_n = pipe_q[1];
endmodule

// File: rtl/spiee_pins.sv
module spiee_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic sck_q, cs_q;
  logic link_on;

  assign link_on  = !cs_n && hold_n;
  assign sck_rise = link_on && sck && !sck_q;
  assign sck_fall = link_on && !sck && sck_q;
  assign cs_rise  = cs_n && !cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end
endmodule

// File: rtl/spiee_seq.sv
module spiee_seq
  import spiee_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              cs_rise,
  input  logic              cs_n,
  input  logic              si,
  input  logic              wr_busy,
  output logic              wel,
  output logic              start_rd,
  output logic              start_stat,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wbyte_valid,
  output logic [ADDR_W-1:0] wbyte_addr,
  output logic [7:0]        wbyte_data,
  output logic              wr_commit,
  output logic              wr_abort
);
  localparam int HI_W = ADDR_W - 8;

  phase_e            phase_q, phase_d;
  logic [2:0]        bit_q, bit_d;
  logic [6:0]        sh_q, sh_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic              is_wr_q, is_wr_d;
  logic              got_q, got_d;
  logic              arm_q, arm_d;
  logic              wel_q, wel_d;
  logic              busy_q;
  logic              wbv_q, wbv_d;
  logic [ADDR_W-1:0] wba_q, wba_d;
  logic [7:0]        wbd_q, wbd_d;
  logic              com_q, com_d;
  logic              abt_q, abt_d;

  logic       byte_done;
  logic [7:0] byte_val;

  assign byte_done  = sck_rise && (bit_q == 3'd7);
  assign byte_val   = {sh_q, si};
  assign rd_addr    = {hi_q, byte_val};
  assign start_rd   = byte_done && (phase_q == PH_ADL) && !is_wr_q;
  assign start_stat = byte_done && (phase_q == PH_CMD) && (byte_val == OP_RDSR);

  // next-state process
  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    hi_d    = hi_q;
    waddr_d = waddr_q;
    is_wr_d = is_wr_q;
    got_d   = got_q;
    arm_d   = arm_q;
    wel_d   = wel_q;
    wbv_d   = 1'b0;
    wba_d   = wba_q;
    wbd_d   = wbd_q;
    com_d   = 1'b0;
    abt_d   = 1'b0;

    // write cycle finished: latch drops
    if (busy_q && !wr_busy) wel_d = 1'b0;

    if (cs_rise) begin
      if (phase_q == PH_WELP) wel_d = arm_q;
      if (phase_q == PH_WR) begin
        if (bit_q == 3'd0 && got_q) com_d = 1'b1;
        else                        abt_d = 1'b1;
      end
    end

    if (cs_n) begin
      phase_d = PH_CMD;
      bit_d   = 3'd0;
      got_d   = 1'b0;
    end else if (sck_rise) begin
      sh_d  = byte_val[6:0];
      bit_d = bit_q + 3'd1;
      if (phase_q == PH_WELP) phase_d = PH_IGN;
      if (bit_q == 3'd7) begin
        unique case (phase_q)
          PH_CMD: begin
            unique case (byte_val)
              OP_READ: begin
                is_wr_d = 1'b0;
                phase_d = wr_busy ? PH_IGN : PH_ADH;
              end
              OP_WRITE: begin
                is_wr_d = 1'b1;
                phase_d = (wel_q && !wr_busy) ? PH_ADH : PH_IGN;
              end
              OP_WREN: begin
                arm_d   = 1'b1;
                phase_d = PH_WELP;
              end
              OP_WRDI: begin
                arm_d   = 1'b0;
                phase_d = PH_WELP;
              end
              OP_RDSR: phase_d = PH_STAT;
              default: phase_d = PH_IGN;
            endcase
          end
          PH_ADH: begin
            hi_d    = byte_val[HI_W-1:0];
            phase_d = PH_ADL;
          end
          PH_ADL: begin
            if (is_wr_q) begin
              waddr_d = {hi_q, byte_val};
              phase_d = PH_WR;
            end else begin
              phase_d = PH_RD;
            end
          end
          PH_WR: begin
            wbv_d   = 1'b1;
            wba_d   = waddr_q;
            wbd_d   = byte_val;
            got_d   = 1'b1;
            waddr_d = {waddr_q[ADDR_W-1:PAGE_W], waddr_q[PAGE_W-1:0] + 1'b1};
          end
          default: ;
        endcase
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      bit_q   <= 3'd0;
      sh_q    <= 7'd0;
      hi_q    <= '0;
      waddr_q <= '0;
      is_wr_q <= 1'b0;
      got_q   <= 1'b0;
      arm_q   <= 1'b0;
      wel_q   <= 1'b0;
      busy_q  <= 1'b0;
      wbv_q   <= 1'b0;
      wba_q   <= '0;
      wbd_q   <= 8'd0;
      com_q   <= 1'b0;
      abt_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      hi_q    <= hi_d;
      waddr_q <= waddr_d;
      is_wr_q <= is_wr_d;
      got_q   <= got_d;
      arm_q   <= arm_d;
      wel_q   <= wel_d;
      busy_q  <= wr_busy;
      wbv_q   <= wbv_d;
      com_q   <= com_d;
      abt_q   <= abt_d;
      if (wbv_d) begin
        wba_q <= wba_d;
        wbd_q <= wbd_d;
      end
    end
  end

  assign wel         = wel_q;
  assign wbyte_valid = wbv_q;
  assign wbyte_addr  = wba_q;
  assign wbyte_data  = wbd_q;
  assign wr_commit   = com_q;
  assign wr_abort    = abt_q;
endmodule

// File: rtl/spiee_tx.sv
module spiee_tx #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_fall,
  input  logic              start_rd,
  input  logic              start_stat,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        stat_byte,
  input  logic [7:0]        mem_rdata,
  output logic              so,
  output logic              out_on,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr
);
  logic              on_q, on_d;
  logic              st_q, st_d;
  logic [2:0]        idx_q, idx_d;
  logic [7:0]        byte_q, byte_d;
  logic              so_q, so_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              fetch_q, fetch_d;
  logic              pend_q;

  // next-state process
  always_comb begin
    on_d    = on_q;
    st_d    = st_q;
    idx_d   = idx_q;
    byte_d  = byte_q;
    so_d    = so_q;
    ptr_d   = ptr_q;
    fetch_d = 1'b0;

    if (pend_q) byte_d = mem_rdata;

    if (cs_n) begin
      on_d = 1'b0;
    end else if (start_rd) begin
      on_d    = 1'b1;
      st_d    = 1'b0;
      idx_d   = 3'd7;
      ptr_d   = rd_addr;
      fetch_d = 1'b1;
    end else if (start_stat) begin
      on_d   = 1'b1;
      st_d   = 1'b1;
      idx_d  = 3'd7;
      byte_d = stat_byte;
    end else if (sck_fall && on_q) begin
      so_d  = byte_q[idx_q];
      idx_d = idx_q - 3'd1;
      if (idx_q == 3'd0) begin
        if (st_q) begin
          byte_d = stat_byte;
        end else begin
          ptr_d   = ptr_q + 1'b1;
          fetch_d = 1'b1;
        end
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= 1'b0;
      st_q    <= 1'b0;
      idx_q   <= 3'd7;
      byte_q  <= 8'd0;
      so_q    <= 1'b0;
      ptr_q   <= '0;
      fetch_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      on_q    <= on_d;
      st_q    <= st_d;
      idx_q   <= idx_d;
      byte_q  <= byte_d;
      so_q    <= so_d;
      ptr_q   <= ptr_d;
      fetch_q <= fetch_d;
      pend_q  <= fetch_q;
    end
  end

  assign so          = so_q;
  assign out_on      = on_q;
  assign mem_rd_en   = fetch_q;
  assign mem_rd_addr = ptr_q;
endmodule

// File: rtl/spiee_front.sv
module spiee_front #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              hold_n,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic [5:0]        stat_hi,
  input  logic              wr_busy,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rdata,
  output logic              wbyte_valid,
  output logic [ADDR_W-1:0] wbyte_addr,
  output logic [7:0]        wbyte_data,
  output logic              wr_commit,
  output logic              wr_abort
);
  logic              srst_n;
  logic              sck_rise, sck_fall, cs_rise;
  logic              wel;
  logic              start_rd, start_stat;
  logic [ADDR_W-1:0] rd_addr;
  logic              out_on;
  logic [7:0]        stat_byte;

  assign stat_byte = {stat_hi, wel, wr_busy};

  spiee_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  spiee_pins u_pins (
    .clk      (clk),
    .rst_n    (srst_n),
    .sck      (sck),
    .cs_n     (cs_n),
    .hold_n   (hold_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_rise  (cs_rise)
  );

  spiee_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_seq (
    .clk         (clk),
    .rst_n       (srst_n),
    .sck_rise    (sck_rise),
    .cs_rise     (cs_rise),
    .cs_n        (cs_n),
    .si          (si),
    .wr_busy     (wr_busy),
    .wel         (wel),
    .start_rd    (start_rd),
    .start_stat  (start_stat),
    .rd_addr     (rd_addr),
    .wbyte_valid (wbyte_valid),
    .wbyte_addr  (wbyte_addr),
    .wbyte_data  (wbyte_data),
    .wr_commit   (wr_commit),
    .wr_abort    (wr_abort)
  );

  spiee_tx #(.ADDR_W(ADDR_W)) u_tx (
    .clk         (clk),
    .rst_n       (srst_n),
    .cs_n        (cs_n),
    .sck_fall    (sck_fall),
    .start_rd    (start_rd),
    .start_stat  (start_stat),
    .rd_addr     (rd_addr),
    .stat_byte   (stat_byte),
    .mem_rdata   (mem_rdata),
    .so          (so),
    .out_on      (out_on),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr)
  );

  assign so_oe = out_on && !cs_n && hold_n;
endmodule

// File: rtl/spiee_front_chk.sv
module spiee_front_chk (
  input logic clk,
  input logic rst_n,
  input logic so,
  input logic sck_fall,
  input logic cs_rise,
  input logic wel,
  input logic wbyte_valid,
  input logic wr_busy,
  input logic wr_commit
);
  // R3
  so_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(so));

  // R5
  wel_set_at_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));

  // R9
  wbyte_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbyte_valid |-> wel);

  // R10
  commit_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(cs_rise));

  // R11
  wel_drop_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wr_busy) && !cs_rise) |=> !wel);
endmodule

bind spiee_front spiee_front_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .so          (so),
  .sck_fall    (sck_fall),
  .cs_rise     (cs_rise),
  .wel         (wel),
  .wbyte_valid (wbyte_valid),
  .wr_busy     (wr_busy),
  .wr_commit   (wr_commit)
);

// File: tb/tb_spiee_front.sv
module tb_spiee_front;
  localparam int HP   = 4;
  localparam int BUSY = 600;
  localparam logic [7:0] SBASE = 8'hB4;

  logic        clk = 1'b0;
  logic        rst_n, sck, cs_n, hold_n, si;
  logic        so, so_oe;
  logic [5:0]  stat_hi;
  logic        wr_busy;
  logic        mem_rd_en;
  logic [11:0] mem_rd_addr;
  logic [7:0]  mem_rdata;
  logic        wbyte_valid;
  logic [11:0] wbyte_addr;
  logic [7:0]  wbyte_data;
  logic        wr_commit, wr_abort;

  always #10 clk = ~clk;

  spiee_front dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .so(so), .so_oe(so_oe), .stat_hi(stat_hi), .wr_busy(wr_busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rdata(mem_rdata),
    .wbyte_valid(wbyte_valid), .wbyte_addr(wbyte_addr), .wbyte_data(wbyte_data),
    .wr_commit(wr_commit), .wr_abort(wr_abort)
  );

  // array and write controller model
  logic [7:0]  mem [0:4095];
  logic [7:0]  ref_mem [0:4095];
  logic [11:0] qa [$];
  logic [7:0]  qd [$];
  int busy_cnt, n_wb, n_com, n_abt;
  int n_vec, n_bad;
  bit mode3;

  assign wr_busy = (busy_cnt != 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 8'(i * 7 + 3);
      busy_cnt <= 0;
      n_wb <= 0; n_com <= 0; n_abt <= 0;
      qa.delete(); qd.delete();
    end else begin
      if (mem_rd_en) mem_rdata <= mem[mem_rd_addr];
      if (wbyte_valid) begin
        qa.push_back(wbyte_addr);
        qd.push_back(wbyte_data);
        n_wb <= n_wb + 1;
      end
      if (wr_abort) begin
        qa.delete(); qd.delete();
        n_abt <= n_abt + 1;
      end
      if (wr_commit) begin
        foreach (qa[k]) mem[qa[k]] <= qd[k];
        qa.delete(); qd.delete();
        n_com <= n_com + 1;
        busy_cnt <= BUSY;
      end else if (busy_cnt > 0) begin
        busy_cnt <= busy_cnt - 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    sck = mode3; tick(HP);
    cs_n = 1'b0; tick(HP);
  endtask

  task automatic desel();
    tick(HP);
    if (!mode3) begin sck = 1'b0; tick(HP); end
    cs_n = 1'b1; tick(2 * HP);
  endtask

  // one byte out on si, one byte in from so; optional hold pause at a bit
  task automatic xbyte(input logic [7:0] tx, input int nb, input int hold_bit,
                       output logic [7:0] rx, output int oe_n);
    logic keep;
    rx = 8'h00; oe_n = 0;
    for (int i = 7; i >= 8 - nb; i--) begin
      sck = 1'b0; si = tx[i]; tick(HP);
      if (i == hold_bit) begin
        keep = so;
        hold_n = 1'b0; tick(2);
        chk("R7", "so_oe while held", int'(so_oe), 0);
        sck = 1'b1; tick(2); sck = 1'b0; tick(2);
        sck = 1'b1; tick(2); sck = 1'b0; tick(2);
        hold_n = 1'b1; tick(2);
        chk("R7", "bit kept across hold", int'(so), int'(keep));
      end
      rx[i] = so;
      if (so_oe) oe_n++;
      sck = 1'b1; tick(HP);
    end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r; int o;
    xbyte(b, 8, -1, r, o);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel(); send(op); desel();
  endtask

  task automatic rdsr(output logic [7:0] s1, output logic [7:0] s2);
    int o;
    sel(); send(8'h05);
    xbyte(8'h00, 8, -1, s1, o);
    xbyte(8'h00, 8, -1, s2, o);
    desel();
  endtask

  task automatic read_chk(input int a, input int n, input int hold_bit, input string req);
    logic [7:0] r; int o;
    sel(); send(8'h03); send(8'(a >> 8)); send(8'(a));
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, 8, (k == 0) ? hold_bit : -1, r, o);
      chk(req, "read byte", int'(r), int'(ref_mem[(a + k) & 12'hFFF]));
      chk(req, "so_oe per bit", o, 8);
    end
    desel();
  endtask

  task automatic wr(input int a, input int n, input int seed, input bit accept);
    logic [7:0] d;
    sel(); send(8'h02); send(8'(a >> 8)); send(8'(a));
    for (int k = 0; k < n; k++) begin
      d = 8'(seed + k * 17);
      send(d);
      if (accept) ref_mem[(a & 12'hFE0) | ((a + k) & 31)] = d;
    end
    desel();
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] s1, s2, r;
    int o, c0, a0, w0;
    for (int i = 0; i < 4096; i++) ref_mem[i] = 8'(i * 7 + 3);
    n_vec = 0; n_bad = 0; mode3 = 1'b0;
    rst_n = 1'b0; cs_n = 1'b1; hold_n = 1'b1; sck = 1'b0; si = 1'b0;
    stat_hi = 6'h2D;
    tick(6); rst_n = 1'b1; tick(6);

    // R12: reset state
    chk("R12", "so_oe after reset", int'(so_oe), 0);

    // R6: status byte and its repetition
    rdsr(s1, s2);
    chk("R6", "status first", int'(s1), int'(SBASE));
    chk("R6", "status repeated", int'(s2), int'(SBASE));

    // R3 R1: read in idle-low mode, top nibble ignored
    read_chk(16'h1234, 3, -1, "R3");

    // R4 R1: idle-high mode read across 0FFFh
    mode3 = 1'b1;
    read_chk(16'h0FFE, 4, -1, "R4");
    mode3 = 1'b0;

    // R5: extra bits after set opcode leave latch clear
    sel(); send(8'h06); send(8'h00); desel();
    rdsr(s1, s2);
    chk("R5", "latch after overrun", int'(s1[1]), 0);

    // R5: clean set
    cmd1(8'h06);
    rdsr(s1, s2);
    chk("R5", "latch after set", int'(s1), int'(SBASE | 8'h02));

    // R5: clear opcode
    cmd1(8'h04);
    rdsr(s1, s2);
    chk("R5", "latch after clear", int'(s1[1]), 0);

    // R9 R10: page-wrapping write
    cmd1(8'h06);
    w0 = n_wb; c0 = n_com;
    wr(12'h01E, 4, 8'hA1, 1'b1);
    tick(2);
    chk("R9", "bytes emitted", n_wb - w0, 4);
    chk("R10", "commit count", n_com - c0, 1);

    // R8 R6: status during the write cycle, read refused
    rdsr(s1, s2);
    chk("R8", "status while busy", int'(s1), int'(SBASE | 8'h03));
    sel(); send(8'h03); send(8'h00); send(8'h00);
    xbyte(8'h00, 8, -1, r, o);
    chk("R8", "refused read so_oe", o, 0);
    desel();

    // R11: latch drops when the cycle ends
    while (wr_busy) tick(1);
    tick(4);
    rdsr(s1, s2);
    chk("R11", "status after cycle", int'(s1), int'(SBASE));

    // R9: written data landed with page wrap
    read_chk(12'h01E, 2, -1, "R9");
    read_chk(12'h000, 2, -1, "R9");

    // R10: partial byte aborts
    cmd1(8'h06);
    c0 = n_com; a0 = n_abt;
    sel(); send(8'h02); send(8'h00); send(8'h40); send(8'h55);
    xbyte(8'h0F, 3, -1, r, o);
    desel();
    chk("R10", "abort count", n_abt - a0, 1);
    chk("R10", "no commit", n_com - c0, 0);
    read_chk(12'h040, 1, -1, "R10");

    // R9: write with latch clear emits nothing
    cmd1(8'h04);
    w0 = n_wb;
    wr(12'h050, 1, 8'h99, 1'b0);
    chk("R9", "refused write bytes", n_wb - w0, 0);
    read_chk(12'h050, 1, -1, "R9");

    // R2: unknown opcode ignores rest, including a read opcode
    sel(); send(8'hAB); send(8'h03); send(8'h00); send(8'h00);
    xbyte(8'h00, 8, -1, r, o);
    chk("R2", "so_oe after unknown opcode", o, 0);
    desel();

    // R7: hold in the middle of read data
    read_chk(12'h300, 2, 4, "R7");

    // R12: deselected output
    chk("R12", "so_oe with cs_n high", int'(so_oe), 0);

    // R2: status write payload has no effect
    sel(); send(8'h01); send(8'hFF); desel();
    rdsr(s1, s2);
    chk("R2", "status after status write", int'(s1), int'(SBASE));

    finish_run();
  end
endmodule